// File: doc/BRIEF.md
# Input-Change Interrupt Status Unit

This block gathers the interrupt sources of a two-channel serial controller and drives a single active-low interrupt request. It watches four general-purpose input pins. Each pin passes through a two-flop synchronizer, and any transition on the synchronized level latches a per-pin change flag. The CPU reads the change flags and the live pin levels together from one register. That read clears every change flag and also clears the combined port-change interrupt bit.

The status register collects eight sources:
- the combined port-change bit, gated by a write-only per-pin enable field;
- two sticky break-change bits, one per channel, each cleared by its own strobe;
- five level sources taken straight from the channels and the counter.

A write-only mask register selects which status bits can pull the interrupt pin low. The mask never changes what the CPU reads.

Top module: `pin_change_irq`

## Requirements
- R1: A read at address 0x4 returns the four change flags in bits 7..4 (bit 4+i belongs to pin i) and the four synchronized pin levels in bits 3..0 (bit i is pin i).
- R2: A transition in either direction on a pin sets that pin's change flag on the third rising clock edge after the pin changes, because it passes two synchronizer flops and an edge compare. The flag is set whatever the enable field holds.
- R3: A read at address 0x4 clears all change flags and status bit 7 at the clock edge that ends the read cycle.
- R4: If a new change is detected in the same cycle as a clearing read, the flag for that change, and status bit 7 when enabled, are set after that edge.
- R5: The level bits are not latched. They show the synchronized pin levels in the cycle of the read, two edges after the pin changes.
- R6: A read at address 0x5 returns the status byte. From bit 7 down to bit 0 it holds: port change, channel B break change, channel B receive ready, channel B transmit ready, counter ready, channel A break change, channel A receive ready, channel A transmit ready. Bits 5, 4, 3, 1 and 0 follow their inputs in the same cycle.
- R7: Status bit 7 is set only by a change on a pin whose bit in the enable field (written at address 0x7, data bits 3..0) is 1.
- R8: irq_n is 0 exactly when some status bit and the matching bit of the mask register (written at address 0x6) are both 1.
- R9: The mask register has no effect on the value read from address 0x5.
- R10: A break-change bit is set by a one-cycle event pulse and stays set until its clear strobe is high at a clock edge. An event and a clear at the same edge leave the bit set.
- R11: After reset, the change flags, status byte, mask and enable field are all zero, and irq_n is 1.
- R12: A read at any address other than 0x4 and 0x5, including the write-only 0x6 and 0x7, returns 0x00. bus_rdata is 0x00 whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe; a read at 0x4 clears the change flags at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational while bus_rd is high) |
| pins_in | input | 4 | Asynchronous general-purpose inputs |
| txa_ready | input | 1 | Channel A transmitter ready level |
| rxa_ready | input | 1 | Channel A receiver ready level |
| brka_evt | input | 1 | Channel A break-change event pulse |
| brka_clr | input | 1 | Channel A break-change clear strobe |
| ctr_ready | input | 1 | Counter ready level |
| txb_ready | input | 1 | Channel B transmitter ready level |
| rxb_ready | input | 1 | Channel B receiver ready level |
| brkb_evt | input | 1 | Channel B break-change event pulse |
| brkb_clr | input | 1 | Channel B break-change clear strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench places a pin transition in the very cycle of a clearing read. A design that lets the clear win would lose that event and read back a zero flag. It changes pins whose enable bits are off, checking that the change flag still sets while status bit 7 stays clear; a design that gates the flag, or ignores the enable, would show the wrong bit. It sets the mask around live status bits to show that the interrupt pin follows the mask and the status read does not. A design that masks the readable status would return a smaller byte. It raises a break event and its clear at the same edge, where a clear-wins design would drop the sticky bit.

// File: rtl/ics_pkg.sv
// Package: shared sizes and register addresses for the input-change interrupt unit.
// Assumes four monitored pins and two serial channels; the byte layouts depend on both.
package ics_pkg;
    parameter int NPINS  = 4;
    parameter int NCHAN  = 2;
    parameter int ADDR_W = 4;
    localparam int DATA_W = 2 * NPINS;

    localparam logic [ADDR_W-1:0] ADDR_CHG  = 4'h4;  // flags + live levels, read clears
    localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h5;  // status byte, read only
    localparam logic [ADDR_W-1:0] ADDR_MASK = 4'h6;  // interrupt mask, write only
    localparam logic [ADDR_W-1:0] ADDR_ENA  = 4'h7;  // per-pin change enable, write only
endpackage

// File: rtl/ics_pin_detect.sv
// Module: two-flop synchronizer and transition detector, one slice per pin.
// Assumes pins are asynchronous; change_o is a one-cycle pulse after each sync transition.
module ics_pin_detect #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_raw,
    output logic [NPINS-1:0] level_o,
    output logic [NPINS-1:0] change_o
);
    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_pin
            logic meta_q, sync_q, last_q;

            // Synchronize the raw pin and keep its previous synchronized level
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    last_q <= 1'b0;
                end else begin
                    meta_q <= pins_raw[g];
                    sync_q <= meta_q;
                    last_q <= sync_q;
                end
            end

            assign level_o[g]  = sync_q;
            assign change_o[g] = sync_q ^ last_q;
        end
    endgenerate
endmodule

// File: rtl/ics_change_flags.sv
// Module: per-pin sticky change flags and the gated port-change summary bit.
// Assumes clr_i is high for one cycle per clearing read; a same-cycle change wins over the clear.
module ics_change_flags #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] change_i,
    input  logic [NPINS-1:0] enable_i,
    input  logic             clr_i,
    output logic [NPINS-1:0] flags_o,
    output logic             port_chg_o
);
    logic [NPINS-1:0] kept;
    logic             any_enabled;

    assign kept        = clr_i ? '0 : flags_o;
    assign any_enabled = |(change_i & enable_i);

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_flag
            // Hold or clear the flag, then set it on a detected change
            always_ff @(posedge clk) begin
                if (!rst_n) flags_o[g] <= 1'b0;
                else        flags_o[g] <= kept[g] | change_i[g];
            end
        end
    endgenerate

    // Summary bit: set by an enabled change, cleared by the same read as the flags
    always_ff @(posedge clk) begin
        if (!rst_n) port_chg_o <= 1'b0;
        else        port_chg_o <= (port_chg_o & ~clr_i) | any_enabled;
    end
endmodule

// File: rtl/ics_status_irq.sv
// Module: assembles the status byte, holds the sticky break bits, drives the masked interrupt.
// Assumes level sources are already synchronous; channel index 0 is A, 1 is B.
module ics_status_irq
    import ics_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_chg_i,
    input  logic [NCHAN-1:0] tx_ready_i,
    input  logic [NCHAN-1:0] rx_ready_i,
    input  logic [NCHAN-1:0] brk_evt_i,
    input  logic [NCHAN-1:0] brk_clr_i,
    input  logic             ctr_ready_i,
    input  logic [7:0]       mask_i,
    output logic [7:0]       status_o,
    output logic             irq_n_o
);
    logic [NCHAN-1:0] brk_q;

    genvar c;
    generate
        for (c = 0; c < NCHAN; c++) begin : g_brk
            // Sticky break-change bit; a same-edge event beats the clear
            always_ff @(posedge clk) begin
                if (!rst_n) brk_q[c] <= 1'b0;
                else        brk_q[c] <= (brk_q[c] & ~brk_clr_i[c]) | brk_evt_i[c];
            end
        end
    endgenerate

    // Fixed bit order of the status byte
    always_comb begin
        status_o = {port_chg_i,
                    brk_q[1], rx_ready_i[1], tx_ready_i[1],
                    ctr_ready_i,
                    brk_q[0], rx_ready_i[0], tx_ready_i[0]};
    end

    assign irq_n_o = ~|(status_o & mask_i);
endmodule

// File: rtl/pin_change_irq.sv
// Module: top of the input-change interrupt status unit; register decode and submodule wiring.
// Assumes one bus access per cycle; bus_rdata is combinational and zero when not reading.
module pin_change_irq
    import ics_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pins_in,
    input  logic              txa_ready,
    input  logic              rxa_ready,
    input  logic              brka_evt,
    input  logic              brka_clr,
    input  logic              ctr_ready,
    input  logic              txb_ready,
    input  logic              rxb_ready,
    input  logic              brkb_evt,
    input  logic              brkb_clr,
    output logic              irq_n
);
    logic [NPINS-1:0] lvl, chg, flags, en_q;
    logic [7:0]       mask_q, status;
    logic             port_chg, rd_clear;

    assign rd_clear = bus_rd && (bus_addr == ADDR_CHG);

    // Write-only mask and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_MASK) mask_q <= bus_wdata;
            if (bus_addr == ADDR_ENA)  en_q   <= bus_wdata[NPINS-1:0];
        end
    end

    ics_pin_detect #(.NPINS(NPINS)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_raw (pins_in),
        .level_o  (lvl),
        .change_o (chg)
    );

    ics_change_flags #(.NPINS(NPINS)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .change_i   (chg),
        .enable_i   (en_q),
        .clr_i      (rd_clear),
        .flags_o    (flags),
        .port_chg_o (port_chg)
    );

    ics_status_irq u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_chg_i  (port_chg),
        .tx_ready_i  ({txb_ready, txa_ready}),
        .rx_ready_i  ({rxb_ready, rxa_ready}),
        .brk_evt_i   ({brkb_evt, brka_evt}),
        .brk_clr_i   ({brkb_clr, brka_clr}),
        .ctr_ready_i (ctr_ready),
        .mask_i      (mask_q),
        .status_o    (status),
        .irq_n_o     (irq_n)
    );

    // Read data selection
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_CHG:  bus_rdata = {flags, lvl};
                ADDR_STAT: bus_rdata = status;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ics_checker.sv
// Module: property checker for pin_change_irq, attached by bind below.
// Assumes the internal signal names of the top; observes only.
module ics_checker
    import ics_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_n,
    input logic              brka_evt,
    input logic              brkb_evt,
    input logic [NPINS-1:0]  lvl,
    input logic [NPINS-1:0]  chg,
    input logic [NPINS-1:0]  flags,
    input logic [NPINS-1:0]  en_q,
    input logic [7:0]        mask_q,
    input logic [7:0]        status
);
    logic rd_chg, rd_stat;
    assign rd_chg  = bus_rd && (bus_addr == ADDR_CHG);
    assign rd_stat = bus_rd && (bus_addr == ADDR_STAT);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_chg && chg == '0) |=> (flags == '0 && !status[7]));

    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((flags & $past(chg)) == $past(chg)));

    assert_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_chg |-> (bus_rdata[NPINS-1:0] == lvl));

    assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[7]) |-> ($past(en_q) != '0));

    assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |-> (irq_n == ~|(bus_rdata & mask_q)));

    assert_brk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (brka_evt || brkb_evt) |=> ((!$past(brka_evt) || status[2]) &&
                                    (!$past(brkb_evt) || status[6])));

    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (irq_n && flags == '0 && status[7] == 1'b0));
endmodule

bind pin_change_irq ics_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .brka_evt  (brka_evt),
    .brkb_evt  (brkb_evt),
    .lvl       (lvl),
    .chg       (chg),
    .flags     (flags),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .status    (status)
);

// File: tb/tb_pin_change_irq.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed corner cases.
module tb_pin_change_irq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [3:0] pins_in;
    logic       txa_ready, rxa_ready, brka_evt, brka_clr, ctr_ready;
    logic       txb_ready, rxb_ready, brkb_evt, brkb_clr;
    logic       irq_n;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    pin_change_irq dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
        .txa_ready(txa_ready), .rxa_ready(rxa_ready), .brka_evt(brka_evt), .brka_clr(brka_clr),
        .ctr_ready(ctr_ready), .txb_ready(txb_ready), .rxb_ready(rxb_ready),
        .brkb_evt(brkb_evt), .brkb_clr(brkb_clr), .irq_n(irq_n)
    );

    // Reference model state: history of sampled pin vectors, newest first
    logic [3:0] hist[$];
    logic [3:0] m_flags, m_en;
    logic [7:0] m_mask;
    logic       m_pc, m_brka, m_brkb;
    bit         m_ready = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_pc, m_brkb, rxb_ready, txb_ready, ctr_ready, m_brka, rxa_ready, txa_ready};
    endfunction

    // Model update on each rising edge, from the requirements
    always @(posedge clk) begin : model
        logic [3:0] seen;
        logic       clr;
        if (!rst_n) begin
            hist = '{4'h0, 4'h0, 4'h0};
            m_flags = '0; m_en = '0; m_mask = '0;
            m_pc = 0; m_brka = 0; m_brkb = 0;
            m_ready = 1;
        end else begin
            seen = hist[1] ^ hist[2];
            clr  = bus_rd && bus_addr == 4'h4;
            m_flags = (clr ? 4'h0 : m_flags) | seen;
            m_pc    = (clr ? 1'b0 : m_pc) | (|(seen & m_en));
            m_brka  = (brka_clr ? 1'b0 : m_brka) | brka_evt;
            m_brkb  = (brkb_clr ? 1'b0 : m_brkb) | brkb_evt;
            if (bus_wr && bus_addr == 4'h6) m_mask = bus_wdata;
            if (bus_wr && bus_addr == 4'h7) m_en   = bus_wdata[3:0];
            hist.push_front(pins_in);
            void'(hist.pop_back());
        end
    end

    // Per-cycle comparison, away from the edges
    always begin : monitor
        logic [7:0] e;
        string      tag;
        @(negedge clk);
        #1;
        if (rst_n && m_ready && !done) begin
            e = 8'h00; tag = "R12";
            if (bus_rd && bus_addr == 4'h4) begin e = {m_flags, hist[1]}; tag = "R1"; end
            else if (bus_rd && bus_addr == 4'h5) begin e = exp_status(); tag = "R6"; end
            chk(tag, bus_rdata, e);
            chk("R8", {7'b0, irq_n}, {7'b0, ~|(exp_status() & m_mask)});
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin : watchdog
        #(4 * 20000);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        logic [7:0] d;
        rst_n = 0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0; pins_in = '0;
        txa_ready = 0; rxa_ready = 0; brka_evt = 0; brka_clr = 0; ctr_ready = 0;
        txb_ready = 0; rxb_ready = 0; brkb_evt = 0; brkb_clr = 0;
        @(negedge clk);
        tick(3);
        chk("R11 irq_n in reset", {7'b0, irq_n}, 8'h01);
        rst_n = 1;
        #1 chk("R11 irq_n after reset", {7'b0, irq_n}, 8'h01);
        rd(4'h5, d); chk("R11 status", d, 8'h00);
        rd(4'h4, d); chk("R11 flags", d, 8'h00);

        // Levels appear after two edges; a change coinciding with the read survives it
        pins_in = 4'b0101;
        tick(2);
        rd(4'h4, d); chk("R5 live level", d, 8'h05);
        rd(4'h4, d); chk("R4 change kept over clear", d, 8'h55);
        rd(4'h4, d); chk("R3 flags cleared", d, 8'h05);
        rd(4'h5, d); chk("R7 no enable no port bit", d, 8'h00);

        // Enabled change on pin 3
        wr(4'h7, 8'h0F);
        pins_in = 4'b1101;
        tick(3);
        rd(4'h5, d); chk("R7 enabled port bit", d, 8'h80);
        rd(4'h4, d); chk("R2 flag pin3", d, 8'h8D);
        rd(4'h4, d); chk("R3 flags cleared by read", d, 8'h0D);
        rd(4'h5, d); chk("R3 port bit cleared", d, 8'h00);

        // Only pin 0 enabled
        wr(4'h7, 8'h01);
        pins_in = 4'b1111;
        tick(3);
        rd(4'h5, d); chk("R7 disabled pin gated", d, 8'h00);
        rd(4'h4, d); chk("R2 flag set while disabled", d, 8'h2F);
        pins_in = 4'b1110;
        tick(3);
        rd(4'h5, d); chk("R7 enabled pin0", d, 8'h80);
        rd(4'h4, d); chk("R1 layout", d, 8'h1E);

        // Level sources, masking and read independence
        txa_ready = 1; ctr_ready = 1; rxb_ready = 1;
        #1 chk("R8 mask zero no irq", {7'b0, irq_n}, 8'h01);
        rd(4'h5, d); chk("R6 level bits", d, 8'h29);
        wr(4'h6, 8'h08);
        #1 chk("R8 masked counter irq", {7'b0, irq_n}, 8'h00);
        rd(4'h5, d); chk("R9 status unaffected by mask", d, 8'h29);
        wr(4'h6, 8'h80);
        #1 chk("R8 mask on idle bit", {7'b0, irq_n}, 8'h01);
        txa_ready = 0; ctr_ready = 0; rxb_ready = 0;

        // Sticky break bits
        brkb_evt = 1; tick(); brkb_evt = 0;
        tick(2);
        rd(4'h5, d); chk("R10 break B sticky", d, 8'h40);
        brkb_clr = 1; tick(); brkb_clr = 0;
        rd(4'h5, d); chk("R10 break B cleared", d, 8'h00);
        brka_evt = 1; brka_clr = 1; tick(); brka_evt = 0; brka_clr = 0;
        rd(4'h5, d); chk("R10 event beats clear", d, 8'h04);
        wr(4'h6, 8'h04);
        #1 chk("R8 break A irq", {7'b0, irq_n}, 8'h00);

        // Write-only addresses read as zero
        rd(4'h6, d); chk("R12 mask reads zero", d, 8'h00);
        rd(4'h7, d); chk("R12 enable reads zero", d, 8'h00);
        tick(2);
        finish_run();
    end
endmodule